// File: doc/BRIEF.md
# Colour Standard Identification Sequencer

This block is the digital search controller of a multistandard colour decoder. It walks through the possible pairings of colour standard and crystal in a fixed order. It stays on each pairing for a set number of fields and waits for an external identification circuit to confirm it. Once a pairing is confirmed, the block locks onto it and reports the pairing on its outputs. A status code sums up the result for a control processor.

The search only visits pairings that make sense. The installed-crystal configuration rules out pairings whose hardware is missing. The forcing bits can narrow the search to one colour family and one crystal, but never to PAL alone or to NTSC alone. Forcing does not change the order of the search. It only removes disallowed pairings, so the sequencer can never settle on one of them. Every pin is a plain level or strobe. Nothing is streamed, so the block has no handshake.

Top module: `std_id_seq`

## Requirements
- R1: After reset the candidate is PAL on the reference crystal (`std_sel`=00, `xtal_ref`=1), not locked, `colour_kill`=1 and `status`=110 when forcing is legal.
- R2: `xtal_cfg` encodes 00 = two 3.6 MHz crystals, 01 = one 3.6 MHz, 10 = one 4.4 MHz, 11 = 3.6 plus 4.4 MHz. Second-crystal candidates are legal only for 00 and 11. SECAM is legal only for 10 and 11.
- R3: The search visits legal candidates in a fixed cyclic order: PAL reference, PAL second, NTSC reference, NTSC second, SECAM reference. Illegal candidates are skipped, so PAL is always tried ahead of SECAM.
- R4: While searching, a candidate is held for `DWELL_FIELDS` (4) field ticks without identification. The sequencer then moves, on that tick's edge, to the next legal candidate.
- R5: A field tick with `ident_ok`=1 while searching locks the candidate. From the following cycle `colour_kill`=0 and the candidate stays put until the lock is lost.
- R6: A locked candidate is released only after `LOSS_FIELDS` (2) consecutive ticks without `ident_ok`. A single miss followed by a hit keeps the lock. After a release, the search restarts on the same candidate with a fresh dwell.
- R7: Forcing codes {`force_mode`,`force_secam`,`force_ref`}: 0xx = auto search; 100 = PAL/NTSC on the second crystal; 101 = PAL/NTSC on the reference crystal; 111 = SECAM on the reference crystal.
- R8: Forcing code 110 is illegal. It allows no candidate, and `status` shows 100 with `colour_kill`=1 in the same cycle.
- R9: When the crystal configuration or forcing leaves no legal candidate (for example, the second crystal forced with a single crystal fitted), colour is switched off: `colour_kill`=1 and `status`=110.
- R10: `status` encodes 000 = PAL second, 001 = PAL reference, 010 = NTSC second, 011 = NTSC reference, 100 = illegal forcing, 101 = SECAM reference, 110 = colour off. Illegal forcing takes priority over colour off. `std_sel` encodes 00 = PAL, 01 = NTSC, 10 = SECAM.
- R11: If the current candidate becomes illegal, `colour_kill` rises in the same cycle. On the next edge the lock is dropped and the next legal candidate in the order of R3 is taken, whether or not a field tick is present.
- R12: `ident_ok` is ignored in cycles without `field_tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_cfg | input | 2 | Installed-crystal configuration (R2) |
| force_mode | input | 1 | Forcing enable |
| force_secam | input | 1 | Forced family: 1 = SECAM, 0 = PAL/NTSC |
| force_ref | input | 1 | Forced crystal: 1 = reference, 0 = second |
| field_tick | input | 1 | One-cycle strobe per field |
| ident_ok | input | 1 | Identification confirmed for this field, valid with `field_tick` |
| std_sel | output | 2 | Selected standard of the current candidate |
| xtal_ref | output | 1 | 1 = reference crystal, 0 = second crystal |
| colour_kill | output | 1 | 1 while not locked on a legal candidate |
| status | output | 3 | Status readout (R10) |

## Verification
A field tick that carries a confirmation can arrive in the same cycle that a change of crystal configuration or forcing makes the current candidate illegal. The bench drives exactly that collision on purpose. It expects legality to win: no lock is taken, and the next legal candidate in order follows. A reference model inside the bench judges each cycle, and random phases hit further collisions between dwell expiry, lock loss and configuration changes.

// File: rtl/std_id_pkg.sv
package std_id_pkg;

  localparam int NCAND = 5;
  localparam int CW    = $clog2(NCAND);

  typedef enum logic [1:0] {
    STD_PAL   = 2'b00,
    STD_NTSC  = 2'b01,
    STD_SECAM = 2'b10
  } std_e;

  typedef struct packed {
    std_e family;
    logic on_ref;
  } cand_t;

  typedef enum logic {
    SEQ_SEARCH = 1'b0,
    SEQ_LOCK   = 1'b1
  } seq_e;

  localparam logic [2:0] ST_PAL_SEC   = 3'b000;
  localparam logic [2:0] ST_PAL_REF   = 3'b001;
  localparam logic [2:0] ST_NTSC_SEC  = 3'b010;
  localparam logic [2:0] ST_NTSC_REF  = 3'b011;
  localparam logic [2:0] ST_ILLEGAL   = 3'b100;
  localparam logic [2:0] ST_SECAM_REF = 3'b101;
  localparam logic [2:0] ST_OFF       = 3'b110;

  // Search order: index 0 is visited first after reset.
  function automatic cand_t cand_decode(input logic [CW-1:0] idx);
    cand_t c;
    case (idx)
      3'd0:    c = '{family: STD_PAL,   on_ref: 1'b1};
      3'd1:    c = '{family: STD_PAL,   on_ref: 1'b0};
      3'd2:    c = '{family: STD_NTSC,  on_ref: 1'b1};
      3'd3:    c = '{family: STD_NTSC,  on_ref: 1'b0};
      default: c = '{family: STD_SECAM, on_ref: 1'b1};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/std_legal_mask.sv
module std_legal_mask
  import std_id_pkg::*;
#(
  parameter int N = NCAND
) (
  input  logic [1:0]   xtal_cfg,
  input  logic         force_mode,
  input  logic         force_secam,
  input  logic         force_ref,
  output logic [N-1:0] mask,
  output logic         illegal_force
);

  logic two_xtal;
  logic has_44;

  assign two_xtal      = (xtal_cfg == 2'b00) || (xtal_cfg == 2'b11);
  assign has_44        = xtal_cfg[1];
  assign illegal_force = force_mode & force_secam & ~force_ref;

  for (genvar g = 0; g < N; g++) begin : g_cand
    localparam cand_t C = cand_decode(CW'(g));
    logic hw_ok;
    logic force_ok;

    if (C.family == STD_SECAM) begin : g_secam
      assign hw_ok    = has_44;
      assign force_ok = ~force_mode | (force_secam & force_ref);
    end else if (C.on_ref) begin : g_ref
      assign hw_ok    = 1'b1;
      assign force_ok = ~force_mode | (~force_secam & force_ref);
    end else begin : g_sec
      assign hw_ok    = two_xtal;
      assign force_ok = ~force_mode | (~force_secam & ~force_ref);
    end

    assign mask[g] = hw_ok & force_ok;
  end

endmodule

// File: rtl/std_next_pick.sv
module std_next_pick
  import std_id_pkg::*;
#(
  parameter int N = NCAND,
  parameter int W = CW
) (
  input  logic [W-1:0] cur,
  input  logic [N-1:0] mask,
  output logic [W-1:0] nxt,
  output logic         any_legal
);

  // Scan from the farthest offset down to the nearest so that the
  // nearest legal successor wins; offset N (cur itself) has the lowest rank.
  always_comb begin
    nxt = cur;
    for (int k = N; k >= 1; k--) begin
      if (mask[(int'(cur) + k) % N]) nxt = W'((int'(cur) + k) % N);
    end
  end

  assign any_legal = |mask;

endmodule

// File: rtl/std_search_fsm.sv
module std_search_fsm
  import std_id_pkg::*;
#(
  parameter int W            = CW,
  parameter int DWELL_FIELDS = 4,
  parameter int LOSS_FIELDS  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         field_tick,
  input  logic         ident_ok,
  input  logic         cur_legal,
  input  logic         any_legal,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] cand,
  output logic         locked
);

  localparam int DW = $clog2(DWELL_FIELDS + 1);
  localparam int LW = $clog2(LOSS_FIELDS + 1);
  localparam logic [DW-1:0] DWELL_LAST = DW'(DWELL_FIELDS - 1);
  localparam logic [LW-1:0] LOSS_LAST  = LW'(LOSS_FIELDS - 1);

  seq_e          state_q;
  logic [W-1:0]  cand_q;
  logic [DW-1:0] dwell_q;
  logic [LW-1:0] miss_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_SEARCH;
      cand_q  <= '0;
      dwell_q <= '0;
      miss_q  <= '0;
    end else if (!cur_legal) begin
      state_q <= SEQ_SEARCH;
      dwell_q <= '0;
      miss_q  <= '0;
      if (any_legal) cand_q <= nxt;
    end else if (field_tick) begin
      case (state_q)
        SEQ_SEARCH: begin
          if (ident_ok) begin
            state_q <= SEQ_LOCK;
            dwell_q <= '0;
            miss_q  <= '0;
          end else if (dwell_q == DWELL_LAST) begin
            cand_q  <= nxt;
            dwell_q <= '0;
          end else begin
            dwell_q <= dwell_q + 1'b1;
          end
        end
        default: begin
          if (ident_ok) begin
            miss_q <= '0;
          end else if (miss_q == LOSS_LAST) begin
            state_q <= SEQ_SEARCH;
            dwell_q <= '0;
            miss_q  <= '0;
          end else begin
            miss_q <= miss_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign cand   = cand_q;
  assign locked = (state_q == SEQ_LOCK);

endmodule

// File: rtl/std_status_enc.sv
module std_status_enc
  import std_id_pkg::*;
(
  input  cand_t      cur,
  input  logic       kill,
  input  logic       illegal_force,
  output logic [2:0] status
);

  always_comb begin
    if (illegal_force)               status = ST_ILLEGAL;
    else if (kill)                   status = ST_OFF;
    else if (cur.family == STD_SECAM) status = ST_SECAM_REF;
    else if (cur.family == STD_NTSC) status = cur.on_ref ? ST_NTSC_REF : ST_NTSC_SEC;
    else                             status = cur.on_ref ? ST_PAL_REF : ST_PAL_SEC;
  end

endmodule

// File: rtl/std_id_seq.sv
module std_id_seq
  import std_id_pkg::*;
#(
  parameter int DWELL_FIELDS = 4,
  parameter int LOSS_FIELDS  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] xtal_cfg,
  input  logic       force_mode,
  input  logic       force_secam,
  input  logic       force_ref,
  input  logic       field_tick,
  input  logic       ident_ok,
  output logic [1:0] std_sel,
  output logic       xtal_ref,
  output logic       colour_kill,
  output logic [2:0] status
);

  logic [NCAND-1:0] mask;
  logic             illegal_force;
  logic [CW-1:0]    cand;
  logic [CW-1:0]    nxt;
  logic             any_legal;
  logic             cur_legal;
  logic             locked;
  cand_t            cur;

  std_legal_mask #(.N(NCAND)) u_mask (
    .xtal_cfg      (xtal_cfg),
    .force_mode    (force_mode),
    .force_secam   (force_secam),
    .force_ref     (force_ref),
    .mask          (mask),
    .illegal_force (illegal_force)
  );

  std_next_pick #(.N(NCAND), .W(CW)) u_pick (
    .cur       (cand),
    .mask      (mask),
    .nxt       (nxt),
    .any_legal (any_legal)
  );

  assign cur_legal = mask[cand];

  std_search_fsm #(
    .W            (CW),
    .DWELL_FIELDS (DWELL_FIELDS),
    .LOSS_FIELDS  (LOSS_FIELDS)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .field_tick (field_tick),
    .ident_ok   (ident_ok),
    .cur_legal  (cur_legal),
    .any_legal  (any_legal),
    .nxt        (nxt),
    .cand       (cand),
    .locked     (locked)
  );

  assign cur         = cand_decode(cand);
  assign std_sel     = cur.family;
  assign xtal_ref    = cur.on_ref;
  assign colour_kill = ~(locked & cur_legal);

  std_status_enc u_stat (
    .cur           (cur),
    .kill          (colour_kill),
    .illegal_force (illegal_force),
    .status        (status)
  );

endmodule

// File: rtl/std_id_seq_chk.sv
module std_id_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] xtal_cfg,
  input logic       force_mode,
  input logic       force_secam,
  input logic       force_ref,
  input logic       field_tick,
  input logic [1:0] std_sel,
  input logic       xtal_ref,
  input logic       colour_kill,
  input logic [2:0] status
);

  a_r2_secam_needs_44: assert property (@(posedge clk) disable iff (!rst_n)
    (!colour_kill && std_sel == 2'b10) |-> xtal_cfg[1]);

  a_r2_second_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
    (!colour_kill && !xtal_ref) |-> (xtal_cfg == 2'b00 || xtal_cfg == 2'b11));

  a_r7_forced_pairing: assert property (@(posedge clk) disable iff (!rst_n)
    (!colour_kill && force_mode) |->
      (((std_sel == 2'b10) == force_secam) && (xtal_ref == force_ref)));

  a_r8_illegal_readout: assert property (@(posedge clk) disable iff (!rst_n)
    (force_mode && force_secam && !force_ref) |-> (status == 3'b100 && colour_kill));

  a_r10_lock_code: assert property (@(posedge clk) disable iff (!rst_n)
    !colour_kill |-> (status[2:1] != 2'b11 && status != 3'b100));

  a_r5_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_tick && !colour_kill) |=> ($stable(std_sel) && $stable(xtal_ref)));

endmodule

bind std_id_seq std_id_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xtal_cfg    (xtal_cfg),
  .force_mode  (force_mode),
  .force_secam (force_secam),
  .force_ref   (force_ref),
  .field_tick  (field_tick),
  .std_sel     (std_sel),
  .xtal_ref    (xtal_ref),
  .colour_kill (colour_kill),
  .status      (status)
);

// File: tb/std_id_seq_tb.sv
module std_id_seq_tb;

  localparam int DWELL = 4;
  localparam int LOSS  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] xtal_cfg = 2'b11;
  logic       force_mode = 1'b0, force_secam = 1'b0, force_ref = 1'b0;
  logic       field_tick = 1'b0, ident_ok = 1'b0;
  logic [1:0] std_sel;
  logic       xtal_ref, colour_kill;
  logic [2:0] status;

  int checks = 0;
  int errors = 0;

  int m_cand, m_dwell, m_miss;
  bit m_lock;

  always #4 clk = ~clk;

  std_id_seq #(.DWELL_FIELDS(DWELL), .LOSS_FIELDS(LOSS)) u_dut (
    .clk(clk), .rst_n(rst_n), .xtal_cfg(xtal_cfg), .force_mode(force_mode),
    .force_secam(force_secam), .force_ref(force_ref), .field_tick(field_tick),
    .ident_ok(ident_ok), .std_sel(std_sel), .xtal_ref(xtal_ref),
    .colour_kill(colour_kill), .status(status)
  );

  // Legal set per requirements R2, R7, R8 (bit i = candidate i of R3 order).
  function automatic logic [4:0] b_mask();
    logic two  = (xtal_cfg == 2'b00) || (xtal_cfg == 2'b11);
    logic ok44 = xtal_cfg[1];
    logic ref_ok = !force_mode || (!force_secam && force_ref);
    logic sec_ok = two && (!force_mode || (!force_secam && !force_ref));
    logic sc_ok  = ok44 && (!force_mode || (force_secam && force_ref));
    return {sc_ok, sec_ok, ref_ok, sec_ok, ref_ok};
  endfunction

  function automatic int b_next(int cur, logic [4:0] m);
    for (int k = 1; k <= 5; k++) if (m[(cur + k) % 5]) return (cur + k) % 5;
    return cur;
  endfunction

  function automatic logic [6:0] b_expect();
    logic [4:0] m = b_mask();
    logic kill = !(m_lock && m[m_cand]);
    logic [1:0] fam = (m_cand < 2) ? 2'b00 : (m_cand < 4) ? 2'b01 : 2'b10;
    logic onref = (m_cand % 2) == 0;
    logic [2:0] st;
    if (force_mode && force_secam && !force_ref) st = 3'b100;
    else if (kill) st = 3'b110;
    else if (m_cand == 4) st = 3'b101;
    else st = {1'b0, fam[0], onref};
    return {fam, onref, kill, st};
  endfunction

  task automatic model_edge();
    logic [4:0] m = b_mask();
    if (!rst_n) begin
      m_cand = 0; m_lock = 0; m_dwell = 0; m_miss = 0;
    end else if (!m[m_cand]) begin
      m_lock = 0; m_dwell = 0; m_miss = 0;
      if (m != 0) m_cand = b_next(m_cand, m);
    end else if (field_tick) begin
      if (!m_lock) begin
        if (ident_ok) begin m_lock = 1; m_dwell = 0; m_miss = 0; end
        else if (m_dwell == DWELL - 1) begin m_cand = b_next(m_cand, m); m_dwell = 0; end
        else m_dwell++;
      end else begin
        if (ident_ok) m_miss = 0;
        else if (m_miss == LOSS - 1) begin m_lock = 0; m_dwell = 0; m_miss = 0; end
        else m_miss++;
      end
    end
  endtask

  // Inputs are set before the call; outputs judged at the falling edge.
  task automatic step(input string tag);
    logic [6:0] exp_v, act_v;
    @(negedge clk);
    exp_v = b_expect();
    act_v = {std_sel, xtal_ref, colour_kill, status};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: {std,ref,kill,status} actual %b expected %b at %0t", tag, act_v, exp_v, $time);
    end
    @(posedge clk);
    model_edge();
    #1;
  endtask

  task automatic tick(input logic ok, input string tag);
    field_tick = 1'b1; ident_ok = ok;
    step(tag);
    field_tick = 1'b0; ident_ok = 1'b0;
    step(tag);
  endtask

  task automatic set_force(input logic [2:0] f);
    {force_mode, force_secam, force_ref} = f;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_cand = 0; m_lock = 0; m_dwell = 0; m_miss = 0;
    @(posedge clk); #1;
    step("R1 reset");
    step("R1 reset");
    rst_n = 1'b1;
    step("R1 reset state");
    checks++;
    if (status !== 3'b110 || colour_kill !== 1'b1) begin
      errors++;
      $display("FAIL R1: status/kill actual %b/%b expected 110/1", status, colour_kill);
    end

    // R4: dwell of 4 misses then move to PAL second
    for (int i = 0; i < DWELL; i++) tick(1'b0, "R4 dwell");
    // R12: ident_ok without field tick is ignored
    ident_ok = 1'b1;
    for (int i = 0; i < 3; i++) step("R12 no tick");
    ident_ok = 1'b0;
    // R5/R10: lock on PAL second -> status 000
    tick(1'b1, "R5 lock");
    step("R10 status code");
    // R6: single miss keeps lock, two misses release
    tick(1'b0, "R6 one miss");
    tick(1'b1, "R6 recover");
    tick(1'b0, "R6 miss a");
    tick(1'b0, "R6 miss b");
    // R3: walk the full order with cfg 11
    for (int i = 0; i < 5 * DWELL; i++) tick(1'b0, "R3 order");
    // R2: single 3.6 crystal -> only reference PAL/NTSC
    xtal_cfg = 2'b01;
    for (int i = 0; i < 3 * DWELL; i++) tick(1'b0, "R2 single xtal");
    xtal_cfg = 2'b10;
    for (int i = 0; i < 3 * DWELL; i++) tick(1'b0, "R2 single 44");
    // R7: forced SECAM and lock
    xtal_cfg = 2'b11; set_force(3'b111);
    step("R7 force secam");
    tick(1'b1, "R7 secam lock");
    step("R10 secam code");
    // R11 collision: candidate turns illegal while a confirming tick arrives
    set_force(3'b000); xtal_cfg = 2'b00;
    field_tick = 1'b1; ident_ok = 1'b1;
    step("R11 illegal with tick");
    field_tick = 1'b0; ident_ok = 1'b0;
    step("R11 moved on");
    // R8: illegal forcing
    set_force(3'b110);
    for (int i = 0; i < 3; i++) tick(1'b1, "R8 illegal force");
    // R9: second crystal forced with single crystal
    set_force(3'b100); xtal_cfg = 2'b01;
    for (int i = 0; i < 3; i++) tick(1'b1, "R9 colour off");
    set_force(3'b101);
    tick(1'b1, "R7 force ref");
    set_force(3'b100); xtal_cfg = 2'b11;
    step("R7 force second");
    tick(1'b1, "R7 second lock");
    set_force(3'b000);

    // Random phase against the model
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 60 == 0) xtal_cfg = 2'($urandom);
      if ($urandom % 90 == 0) set_force(($urandom % 2) ? 3'($urandom) : 3'b000);
      field_tick = ($urandom % 3 == 0);
      ident_ok   = ($urandom % 10 < 3);
      step("R3 random");
    end
    field_tick = 1'b0; ident_ok = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule